// File: doc/BRIEF.md
# Master UART Request-Response Sequencer

This block carries out one master-side serial exchange at a time. Software first fills a shared 127-byte buffer with the outgoing request through a simple host port. It then programs how many bytes to send and how many response bytes to expect. A strobe from an external cycle timer starts the exchange. The sequencer sends the request bytes one after another as asynchronous characters. It then listens, and stores each received character in the same buffer directly after the request.

An exchange ends in one of two ways. If the expected number of response bytes arrives, a ready flag is raised. If the line stays quiet for a programmable number of bit times before the count is reached, a count-error flag is raised; this includes the case where nothing arrives. Parity, stop-bit and buffer-overflow problems are also flagged. The ready and count-error flags can each drive an interrupt through its own enable. Reading the status, signalled by a one-cycle read strobe, clears every flag.

The controller has four states. IDLE waits for a start strobe while the channel is in serial mode. FETCH hands the next request byte to the transmitter. SEND waits for that character to finish. LISTEN counts response bytes and measures the idle gap. The transitions are:
- IDLE to FETCH on an accepted start with a non-zero send count.
- IDLE to LISTEN on an accepted start with a send count of zero.
- FETCH to SEND after one cycle.
- SEND to FETCH when a character ends and more bytes remain.
- SEND to LISTEN when the last character ends.
- LISTEN to IDLE when the count is met (ready) or the idle gap expires (count error).

Top module: `uart_xchg_seq`

## Requirements
- R1: Each character is a 0 start bit, eight data bits least significant first, an even-parity bit and a 1 stop bit. Each bit lasts 16 × `baud_div` clock cycles; a value of 0 is treated as 1.
- R2: After an accepted start, buffer bytes at addresses 0 to `tx_num`-1 are sent on `line_tx` in rising address order.
- R3: The n-th response byte (n counted from 0) is written at address `tx_num`+n. A byte that would land at address 127 or above is dropped and sets `stat_ovf`, but it still counts toward the receive total.
- R4: A received character whose data and parity bits have odd combined parity sets `stat_perr`. One whose stop-bit sample is 0 sets `stat_ferr`. The byte is stored and counted in both cases.
- R5: `stat_rdy` is set and the exchange ends once all `tx_num` bytes have been sent and `rx_num` bytes have been received. With `rx_num` = 0 this happens right after the last transmit character.
- R6: In LISTEN, if no character starts for `idle_bits` × 16 ticks while the received count is below `rx_num`, then `stat_nume` is set and the exchange ends. The gap is counted from the end of the last character, or from the end of transmission when nothing has arrived.
- R7: `irq` is high while (`stat_rdy` and `rdy_ie`) or (`stat_nume` and `nume_ie`). A one-cycle `stat_rd` pulse while idle clears all five status flags and so drops `irq`.
- R8: A start strobe arriving while `busy` is high is ignored. The running exchange is neither restarted nor extended.
- R9: A start is accepted only when `uart_en` is 1 and `raw_mode` is 0; otherwise `busy` stays 0. `line_tx` is 1 whenever `busy` is 0.
- R10: After reset, `busy`, `irq` and all status flags are 0, and `line_tx` is 1.
- R11: Host writes take effect only while `busy` is 0. `host_rdata` shows the byte at `host_addr` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| uart_en | input | 1 | Serial mode selected |
| raw_mode | input | 1 | Raw pin mode; must be 0 for serial operation |
| baud_div | input | 16 | Clock cycles per 1/16 bit |
| tx_num | input | 7 | Bytes to send, latched at start |
| rx_num | input | 7 | Response bytes expected, latched at start |
| idle_bits | input | 8 | Idle gap limit in bit times |
| start_i | input | 1 | Cycle-timer start strobe |
| host_we | input | 1 | Host buffer write enable |
| host_addr | input | 7 | Host buffer address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, one cycle after address |
| stat_rd | input | 1 | Status read strobe; clears flags |
| rdy_ie | input | 1 | Ready interrupt enable |
| nume_ie | input | 1 | Count-error interrupt enable |
| line_rx | input | 1 | Serial receive line |
| line_tx | output | 1 | Serial transmit line |
| busy | output | 1 | Exchange in progress |
| stat_rdy | output | 1 | Ready flag |
| stat_nume | output | 1 | Count-error flag |
| stat_perr | output | 1 | Parity error flag |
| stat_ferr | output | 1 | Stop-bit error flag |
| stat_ovf | output | 1 | Buffer overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps every pairing of send and receive counts from zero to three. This covers the zero-length cases: a design that waited for a character before checking the count would hang or report a count error where ready is due. Short and silent responses must end in a count error at the right moment: too early cuts off slow devices, and never leaves the channel stuck busy. A 126-byte request forces the response across the buffer end, so a missing overflow guard would wrap around and overwrite the request. Corrupted parity and stop bits, a second start mid-exchange, a start in the wrong mode and a slower divider catch flags that never set, restarts that resend the first byte, and bit timing that drifts.

// File: rtl/uxs_pkg.sv
package uxs_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_FETCH,
        SQ_SEND,
        SQ_LISTEN
    } sq_state_e;

    localparam int SUB_TICKS = 16;

endpackage

// File: rtl/uxs_baud_gen.sv
module uxs_baud_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] last;

    assign last = (div <= DIV_W'(1)) ? '0 : div - 1'b1;
    assign tick = (cnt >= last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= tick ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/uxs_tx_engine.sv
module uxs_tx_engine (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       load,
    input  logic [7:0] din,
    output logic       done,
    output logic       txd
);
    logic [10:0] sh;
    logic [3:0]  tcnt;
    logic [3:0]  bcnt;
    logic        act;

    assign txd = act ? sh[0] : 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= '1; tcnt <= '0; bcnt <= '0; act <= 1'b0; done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load && !act) begin
                sh   <= {1'b1, ^din, din, 1'b0};
                act  <= 1'b1;
                tcnt <= '0;
                bcnt <= '0;
            end else if (act && tick) begin
                if (tcnt == 4'd15) begin
                    tcnt <= '0;
                    sh   <= {1'b1, sh[10:1]};
                    if (bcnt == 4'd10) begin
                        act  <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        bcnt <= bcnt + 1'b1;
                    end
                end else begin
                    tcnt <= tcnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/uxs_rx_engine.sv
module uxs_rx_engine (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxd,
    output logic       busy,
    output logic       valid,
    output logic [7:0] data,
    output logic       perr,
    output logic       ferr
);
    logic       s1, s2;
    logic [8:0] sh;
    logic [3:0] tcnt;
    logic [3:0] bcnt;
    logic       act;

    assign busy = act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b1; s2 <= 1'b1; sh <= '0; tcnt <= '0; bcnt <= '0;
            act <= 1'b0; valid <= 1'b0; data <= '0; perr <= 1'b0; ferr <= 1'b0;
        end else begin
            s1    <= rxd;
            s2    <= s1;
            valid <= 1'b0;
            if (tick) begin
                if (!act) begin
                    if (!s2) begin
                        act  <= 1'b1;
                        tcnt <= '0;
                        bcnt <= '0;
                    end
                end else if (tcnt == ((bcnt == 4'd0) ? 4'd7 : 4'd15)) begin
                    tcnt <= '0;
                    if (bcnt == 4'd0) begin
                        if (s2) act <= 1'b0;
                        else    bcnt <= 4'd1;
                    end else if (bcnt == 4'd10) begin
                        act   <= 1'b0;
                        valid <= 1'b1;
                        data  <= sh[7:0];
                        perr  <= ^sh;
                        ferr  <= !s2;
                    end else begin
                        sh   <= {s2, sh[8:1]};
                        bcnt <= bcnt + 1'b1;
                    end
                end else begin
                    tcnt <= tcnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/uxs_trx_buffer.sv
module uxs_trx_buffer #(
    parameter int DEPTH = 127,
    parameter int AW    = 7
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [7:0]    rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [7:0]    rdata_b
);
    logic [7:0] mem [DEPTH];

    assign rdata_a = (raddr_a < AW'(DEPTH)) ? mem[raddr_a] : 8'h00;

    always_ff @(posedge clk) begin
        if (we && (waddr < AW'(DEPTH))) mem[waddr] <= wdata;
        rdata_b <= (raddr_b < AW'(DEPTH)) ? mem[raddr_b] : 8'h00;
    end
endmodule

// File: rtl/uart_xchg_seq.sv
module uart_xchg_seq
    import uxs_pkg::*;
#(
    parameter int BUF_DEPTH = 127,
    parameter int DIV_W     = 16,
    parameter int IDLE_W    = 8,
    localparam int AW       = $clog2(BUF_DEPTH + 1),
    localparam int CW       = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              uart_en,
    input  logic              raw_mode,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic [AW-1:0]     tx_num,
    input  logic [AW-1:0]     rx_num,
    input  logic [IDLE_W-1:0] idle_bits,
    input  logic              start_i,
    input  logic              host_we,
    input  logic [AW-1:0]     host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              stat_rd,
    input  logic              rdy_ie,
    input  logic              nume_ie,
    input  logic              line_rx,
    output logic              line_tx,
    output logic              busy,
    output logic              stat_rdy,
    output logic              stat_nume,
    output logic              stat_perr,
    output logic              stat_ferr,
    output logic              stat_ovf,
    output logic              irq
);
    sq_state_e        state, nxt;
    logic             tick, tx_done;
    logic             rx_busy, rx_valid, rx_perr, rx_ferr;
    logic [7:0]       rx_byte, tx_byte;
    logic [AW-1:0]    cfg_tx, cfg_rx, idx, wptr;
    logic [CW-1:0]    rcnt;
    logic [IDLE_W+3:0] idle_cnt, limit;
    logic             mode_ok, accept, got_all, idle_hit, rx_in, room, buf_we, host_ok;

    assign mode_ok  = uart_en && !raw_mode;
    assign accept   = (state == SQ_IDLE) && start_i && mode_ok;
    assign limit    = {idle_bits, 4'b0000};
    assign got_all  = (rcnt == {1'b0, cfg_rx});
    assign idle_hit = (idle_cnt == limit);
    assign room     = (wptr != AW'(BUF_DEPTH));
    assign rx_in    = (state == SQ_LISTEN) && rx_valid && !got_all;
    assign buf_we   = rx_in && room;
    assign host_ok  = host_we && (state == SQ_IDLE);
    assign busy     = (state != SQ_IDLE);
    assign irq      = (stat_rdy && rdy_ie) || (stat_nume && nume_ie);

    uxs_baud_gen #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick)
    );

    uxs_tx_engine u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(state == SQ_FETCH),
        .din(tx_byte), .done(tx_done), .txd(line_tx)
    );

    uxs_rx_engine u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(line_rx), .busy(rx_busy),
        .valid(rx_valid), .data(rx_byte), .perr(rx_perr), .ferr(rx_ferr)
    );

    uxs_trx_buffer #(.DEPTH(BUF_DEPTH), .AW(AW)) u_buf (
        .clk(clk), .we(buf_we || host_ok),
        .waddr(buf_we ? wptr : host_addr), .wdata(buf_we ? rx_byte : host_wdata),
        .raddr_a(idx), .rdata_a(tx_byte), .raddr_b(host_addr), .rdata_b(host_rdata)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            SQ_IDLE:   if (accept) nxt = (tx_num == '0) ? SQ_LISTEN : SQ_FETCH;
            SQ_FETCH:  nxt = SQ_SEND;
            SQ_SEND:   if (tx_done) nxt = ((idx + 1'b1) == cfg_tx) ? SQ_LISTEN : SQ_FETCH;
            SQ_LISTEN: if (got_all || idle_hit) nxt = SQ_IDLE;
            default:   nxt = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SQ_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_tx <= '0; cfg_rx <= '0; idx <= '0; wptr <= '0; rcnt <= '0; idle_cnt <= '0;
            stat_rdy <= 1'b0; stat_nume <= 1'b0; stat_perr <= 1'b0;
            stat_ferr <= 1'b0; stat_ovf <= 1'b0;
        end else begin
            if (accept) begin
                cfg_tx <= tx_num;
                cfg_rx <= rx_num;
                idx    <= '0;
                wptr   <= tx_num;
                rcnt   <= '0;
            end
            if ((state == SQ_SEND) && tx_done) idx <= idx + 1'b1;
            if (rx_in) begin
                rcnt <= rcnt + 1'b1;
                if (room) wptr <= wptr + 1'b1;
            end
            if ((state != SQ_LISTEN) || rx_busy || rx_in) idle_cnt <= '0;
            else if (tick && !idle_hit)                   idle_cnt <= idle_cnt + 1'b1;

            if (stat_rd) begin
                stat_rdy <= 1'b0; stat_nume <= 1'b0; stat_perr <= 1'b0;
                stat_ferr <= 1'b0; stat_ovf <= 1'b0;
            end
            if ((state == SQ_LISTEN) && got_all)              stat_rdy  <= 1'b1;
            if ((state == SQ_LISTEN) && !got_all && idle_hit) stat_nume <= 1'b1;
            if (rx_in && rx_perr)                             stat_perr <= 1'b1;
            if (rx_in && rx_ferr)                             stat_ferr <= 1'b1;
            if (rx_in && !room)                               stat_ovf  <= 1'b1;
        end
    end
endmodule

// File: rtl/uxs_seq_checker.sv
module uxs_seq_checker (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic uart_en,
    input logic raw_mode,
    input logic busy,
    input logic line_tx,
    input logic stat_rd,
    input logic stat_rdy,
    input logic stat_nume,
    input logic stat_ovf
);
    p_line_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> line_tx);

    p_start_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(start_i) && $past(uart_en) && !$past(raw_mode)));

    p_ready_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_rdy) |-> ($past(busy) && !busy));

    p_nume_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_nume) |-> ($past(busy) && !busy));

    p_clear_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stat_rd) && !$past(busy)) |-> (!stat_rdy && !stat_nume));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_ovf) |-> $past(busy));
endmodule

bind uart_xchg_seq uxs_seq_checker chk_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .uart_en(uart_en),
    .raw_mode(raw_mode), .busy(busy), .line_tx(line_tx), .stat_rd(stat_rd),
    .stat_rdy(stat_rdy), .stat_nume(stat_nume), .stat_ovf(stat_ovf)
);

// File: tb/uart_xchg_seq_tb_top.sv
module uart_xchg_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        uart_en = 1'b1, raw_mode = 1'b0;
    logic [15:0] baud_div = 16'd1;
    logic [6:0]  tx_num = '0, rx_num = '0, host_addr = '0;
    logic [7:0]  idle_bits = 8'd6, host_wdata = '0;
    logic        start_i = 1'b0, host_we = 1'b0, stat_rd = 1'b0;
    logic        rdy_ie = 1'b1, nume_ie = 1'b1, line_rx = 1'b1;
    logic [7:0]  host_rdata;
    logic        line_tx, busy, stat_rdy, stat_nume, stat_perr, stat_ferr, stat_ovf, irq;

    int n_chk = 0, n_fail = 0, cyc = 0;

    always #5 clk = ~clk;

    uart_xchg_seq dut_i (
        .clk(clk), .rst_n(rst_n), .uart_en(uart_en), .raw_mode(raw_mode),
        .baud_div(baud_div), .tx_num(tx_num), .rx_num(rx_num), .idle_bits(idle_bits),
        .start_i(start_i), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .stat_rd(stat_rd),
        .rdy_ie(rdy_ie), .nume_ie(nume_ie), .line_rx(line_rx), .line_tx(line_tx),
        .busy(busy), .stat_rdy(stat_rdy), .stat_nume(stat_nume), .stat_perr(stat_perr),
        .stat_ferr(stat_ferr), .stat_ovf(stat_ovf), .irq(irq)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            summary();
        end
    end

    function automatic logic [7:0] tx_val(int i, int n);
        return 8'(i * 37 + n * 11 + 3);
    endfunction

    function automatic logic [7:0] rx_val(int j, int n);
        return 8'(j * 91 + n * 29 + 90);
    endfunction

    task automatic host_wr(int a, logic [7:0] d);
        @(negedge clk); host_we = 1'b1; host_addr = 7'(a); host_wdata = d;
        @(negedge clk); host_we = 1'b0;
    endtask

    task automatic host_rd(int a, output logic [7:0] d);
        @(negedge clk); host_addr = 7'(a);
        @(negedge clk); d = host_rdata;
    endtask

    task automatic clear_stat();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    // Capture one character from line_tx and compare it with the expected byte (R1, R2)
    task automatic mon_byte(int p, logic [7:0] exp);
        int w = 0;
        logic s, par, stp;
        logic [7:0] d;
        while (line_tx !== 1'b0 && w < 40 * p) begin @(negedge clk); w++; end
        chk("R2 character appears", int'(line_tx === 1'b0), 1);
        repeat (p / 2) @(negedge clk);
        s = line_tx;
        for (int k = 0; k < 8; k++) begin
            repeat (p) @(negedge clk);
            d[k] = line_tx;
        end
        repeat (p) @(negedge clk); par = line_tx;
        repeat (p) @(negedge clk); stp = line_tx;
        chk("R2 data byte", int'(d), int'(exp));
        chk("R1 start/parity/stop", int'({s, par, stp}), int'({1'b0, ^exp, 1'b1}));
    endtask

    task automatic dev_byte(int p, logic [7:0] d, bit bad_par, bit bad_stop);
        line_rx = 1'b0;
        repeat (p) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            line_rx = d[k];
            repeat (p) @(negedge clk);
        end
        line_rx = (^d) ^ bad_par;
        repeat (p) @(negedge clk);
        line_rx = !bad_stop;
        repeat (p) @(negedge clk);
        line_rx = 1'b1;
    endtask

    task automatic wait_idle(int p);
        int w = 0;
        while (busy && w < 60 * p + 4000) begin @(negedge clk); w++; end
        chk("exchange terminates", int'(busy), 0);
    endtask

    task automatic xchg(int bd, int txn, int rxn, int nsend);
        int p = 16 * bd;
        baud_div = 16'(bd); tx_num = 7'(txn); rx_num = 7'(rxn);
        for (int i = 0; i < txn; i++) host_wr(i, tx_val(i, txn));
        clear_stat();
        pulse_start();
        for (int i = 0; i < txn; i++) mon_byte(p, tx_val(i, txn));
        repeat (2 * p) @(negedge clk);
        for (int j = 0; j < nsend; j++) dev_byte(p, rx_val(j, rxn), 1'b0, 1'b0);
        wait_idle(p);
    endtask

    initial begin
        logic [7:0] rb;
        int lim;
        repeat (3) @(negedge clk);
        chk("R10 busy after reset", int'(busy), 0);
        chk("R10 line_tx after reset", int'(line_tx), 1);
        chk("R10 flags after reset",
            int'({stat_rdy, stat_nume, stat_perr, stat_ferr, stat_ovf, irq}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R5/R3 sweep of send and receive counts 0..3
        for (int t = 0; t < 4; t++) begin
            for (int r = 0; r < 4; r++) begin
                xchg(1, t, r, r);
                chk("R5 ready after full exchange", int'(stat_rdy), 1);
                chk("R6 no count error when matched", int'(stat_nume), 0);
                chk("R7 irq with ready enabled", int'(irq), 1);
                chk("R3 no overflow in range", int'(stat_ovf), 0);
                for (int j = 0; j < r; j++) begin
                    host_rd(t + j, rb);
                    chk("R3 response stored after request", int'(rb), int'(rx_val(j, r)));
                end
            end
        end

        // R7 interrupt gating and clear on read
        rdy_ie = 1'b0; @(negedge clk);
        chk("R7 irq masked", int'(irq), 0);
        rdy_ie = 1'b1; @(negedge clk);
        clear_stat();
        chk("R7 read clears ready and irq", int'({stat_rdy, irq}), 0);

        // R6 short response
        xchg(1, 1, 3, 2);
        chk("R6 count error on short response", int'(stat_nume), 1);
        chk("R5 no ready on short response", int'(stat_rdy), 0);
        chk("R7 irq on count error", int'(irq), 1);
        nume_ie = 1'b0; @(negedge clk);
        chk("R7 count-error irq masked", int'(irq), 0);
        nume_ie = 1'b1;
        host_rd(2, rb);
        chk("R3 partial response stored", int'(rb), int'(rx_val(1, 3)));

        // R6 silent device
        xchg(1, 1, 2, 0);
        chk("R6 count error with no response", int'(stat_nume), 1);

        // R6 idle window timing, R11 host write blocked while busy
        host_wr(100, 8'h11);
        clear_stat();
        tx_num = 7'd0; rx_num = 7'd1; baud_div = 16'd1; idle_bits = 8'd6;
        lim = 6 * 16;
        pulse_start();
        host_wr(100, 8'hEE);
        repeat (lim - 5) @(negedge clk);
        chk("R6 still listening before gap expires", int'(busy), 1);
        repeat (7) @(negedge clk);
        chk("R6 ended after gap", int'(busy), 0);
        chk("R6 count error after gap", int'(stat_nume), 1);
        host_rd(100, rb);
        chk("R11 write ignored while busy", int'(rb), 'h11);
        host_wr(100, 8'h22);
        host_rd(100, rb);
        chk("R11 write accepted while idle", int'(rb), 'h22);

        // R4 parity error
        clear_stat();
        tx_num = 7'd0; rx_num = 7'd1;
        pulse_start();
        dev_byte(16, 8'h5A, 1'b1, 1'b0);
        wait_idle(16);
        chk("R4 parity error flagged", int'({stat_perr, stat_ferr}), 2);
        chk("R4 errored byte counted", int'(stat_rdy), 1);
        host_rd(0, rb);
        chk("R4 errored byte stored", int'(rb), 'h5A);
        clear_stat();
        chk("R7 read clears parity flag", int'(stat_perr), 0);

        // R4 stop-bit error
        pulse_start();
        dev_byte(16, 8'h3C, 1'b0, 1'b1);
        wait_idle(16);
        chk("R4 stop error flagged", int'({stat_perr, stat_ferr}), 1);
        repeat (40) @(negedge clk);

        // R8 start while busy
        clear_stat();
        tx_num = 7'd2; rx_num = 7'd1;
        host_wr(0, 8'hA5); host_wr(1, 8'h0F);
        pulse_start();
        mon_byte(16, 8'hA5);
        pulse_start();
        mon_byte(16, 8'h0F);
        repeat (32) @(negedge clk);
        dev_byte(16, 8'h77, 1'b0, 1'b0);
        wait_idle(16);
        chk("R8 exchange completes once", int'(stat_rdy), 1);
        repeat (40) @(negedge clk);
        chk("R8 no restart after ignored start", int'({busy, line_tx}), 1);

        // R9 mode gating
        clear_stat();
        uart_en = 1'b0;
        pulse_start();
        repeat (3) @(negedge clk);
        chk("R9 start ignored when serial mode off", int'({busy, line_tx}), 1);
        uart_en = 1'b1; raw_mode = 1'b1;
        pulse_start();
        repeat (3) @(negedge clk);
        chk("R9 start ignored in raw mode", int'({busy, line_tx}), 1);
        raw_mode = 1'b0;

        // R1 slower divider
        xchg(3, 2, 2, 2);
        chk("R1 ready at divider 3", int'(stat_rdy), 1);
        host_rd(3, rb);
        chk("R1 received byte at divider 3", int'(rb), int'(rx_val(1, 2)));

        // R3 overflow at buffer end
        xchg(1, 126, 3, 3);
        chk("R3 overflow flagged", int'(stat_ovf), 1);
        chk("R3 ready counts dropped bytes", int'(stat_rdy), 1);
        host_rd(126, rb);
        chk("R3 last slot holds first response", int'(rb), int'(rx_val(0, 3)));
        host_rd(0, rb);
        chk("R3 request not overwritten", int'(rb), int'(tx_val(0, 126)));

        summary();
    end
endmodule